// File: doc/BRIEF.md
# Packed Vector Rounding Average Unit

This block takes two 128-bit packed operands and returns, for every element position, the average of the two elements rounded towards positive infinity. A single operation treats both operands and the result as one element type. Two bits choose 8-, 16- or 32-bit elements, one bit chooses signed or unsigned arithmetic, and one bit chooses whether all 128 bits take part or only the low 64.

The arithmetic runs on one ripple adder built from 8-bit segments. The segments are joined into wider lanes at run time. Each lane forms the value a + b + 1 one bit wider than the lane, which keeps the carry or sign, then shifts it right by one, so the result always fits back into the lane. The operation is accepted when `inValid` is high, and the result is presented one clock later together with a one-cycle `outValid`.

Top module: `simd_round_avg`

## Requirements
- R1: For each lane, the result equals floor((a + b + 1) / 2), computed without overflow. With unsigned 8-bit lanes, 0xFF and 0xFF give 0xFF, 0xFF and 0x00 give 0x80, and 0x01 and 0x02 give 0x02.
- R2: Signed lanes use two's complement. With 8-bit lanes, 0x80 and 0x80 give 0x80, 0x7F and 0x7F give 0x7F, 0xFF and 0x00 give 0x00, 0x80 and 0x7F give 0x00, and 0xFD and 0x00 give 0xFF.
- R3: `laneSize` selects the lane width: 2'b00 for 8 bits, 2'b01 for 16 bits and 2'b10 for 32 bits. Lane k occupies bits [k*w +: w].
- R4: `isUnsigned` = 0 selects signed lanes and `isUnsigned` = 1 selects unsigned lanes. The same operands can give different results in the two modes.
- R5: No carry crosses a lane boundary at any lane width. For example, unsigned 8-bit lanes with all-0xFF and all-0x01 operands give 0x80 in every byte.
- R6: When `fullWidth` = 0, result bits [127:64] are zero and the low 64 bits are computed normally. When `fullWidth` = 1, all 128 bits are computed.
- R7: `laneSize` = 2'b11 is reserved. An accepted operation with this code raises `illegalOp` in the same cycle as its `outValid`, and the result is all zeros. `illegalOp` is low at every other time.
- R8: `outValid` is high exactly in the cycle after a cycle with `inValid` high. In cycles that follow one with `inValid` low, `result` holds its previous value.
- R9: The synchronous active-high reset clears `outValid`, `illegalOp` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands and controls are sampled when high |
| opA | input | 128 | First packed operand |
| opB | input | 128 | Second packed operand |
| laneSize | input | 2 | Lane width code: 00 = 8, 01 = 16, 10 = 32, 11 = reserved |
| isUnsigned | input | 1 | 0 = signed lanes, 1 = unsigned lanes |
| fullWidth | input | 1 | 1 = all 128 bits, 0 = low 64 bits only |
| outValid | output | 1 | Result valid, one cycle after acceptance |
| result | output | 128 | Registered packed rounded averages |
| illegalOp | output | 1 | Reserved lane width was requested |

## Verification
The properties assume that the controls and operands are steady around each clock edge, and that reset is held for at least one edge before any operation is issued. The bounds property for unsigned bytes also assumes that operands of any value may arrive. The bench therefore drives every input on the falling edge and holds `inValid` low throughout reset. It mixes directed extreme values, including all-ones, all-zero, minimum signed and maximum signed elements, with random operands. All four lane-size codes, both signedness settings and both width settings appear, in both back-to-back and idle-separated streams.

// File: rtl/ravg_pkg.sv
package ravg_pkg;
  parameter int VEC_W = 128;
  parameter int SEG_W = 8;
  localparam int NSEG = VEC_W / SEG_W;

  typedef enum logic [1:0] {
    SZ_SEG  = 2'b00,
    SZ_DBL  = 2'b01,
    SZ_QUAD = 2'b10,
    SZ_RSVD = 2'b11
  } laneSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic            load;
    logic            illegal;
    logic            signedLanes;
    logic            upperOn;
    logic [NSEG-1:0] segFirst;  // segment starts a lane
    logic [NSEG-1:0] segLast;   // segment ends a lane
  } dpCtrl_t;
endpackage

// File: rtl/ravg_ctrl.sv
module ravg_ctrl
  import ravg_pkg::*;
#(
  parameter int NUM_SEG = NSEG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic [1:0]    laneSize,
  input  logic          isUnsigned,
  input  logic          fullWidth,
  output dpCtrl_t       strobe,
  output logic          outValid,
  output logic          illegalOp
);
  logic [NUM_SEG-1:0] firstV;
  logic [NUM_SEG-1:0] lastV;
  logic               rsvd;

  assign rsvd = (laneSize == SZ_RSVD);

  // lane boundary masks; lanes span 1, 2 or 4 segments
  for (genvar i = 0; i < NUM_SEG; i++) begin : g_bound
    assign firstV[i] = (laneSize == SZ_SEG)
                    || ((laneSize == SZ_DBL)  && ((i % 2) == 0))
                    || ((laneSize == SZ_QUAD) && ((i % 4) == 0));
    assign lastV[i]  = (laneSize == SZ_SEG)
                    || ((laneSize == SZ_DBL)  && ((i % 2) == 1))
                    || ((laneSize == SZ_QUAD) && ((i % 4) == 3));
  end

  always_comb begin
    strobe.load        = inValid;
    strobe.illegal     = rsvd;
    strobe.signedLanes = !isUnsigned;
    strobe.upperOn     = fullWidth;
    strobe.segFirst    = firstV;
    strobe.segLast     = lastV;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      outValid  <= inValid;
      illegalOp <= inValid && rsvd;
    end
  end
endmodule

// File: rtl/ravg_dp.sv
module ravg_dp
  import ravg_pkg::*;
#(
  parameter int DATA_W  = VEC_W,
  parameter int PIECE_W = SEG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  dpCtrl_t           strobe,
  output logic [DATA_W-1:0] result
);
  localparam int PIECES = DATA_W / PIECE_W;
  localparam int HALF_W = DATA_W / 2;

  logic [PIECES-1:0] segCarry;
  logic [PIECES-1:0] segExt;
  logic [DATA_W-1:0] sumVec;
  logic [DATA_W-1:0] halved;
  logic [DATA_W-1:0] nextRes;

  for (genvar i = 0; i < PIECES; i++) begin : g_seg
    logic               cin;
    logic [PIECE_W:0]   segSum;
    logic               aTop;
    logic               bTop;

    if (i == 0) begin : g_c0
      assign cin = strobe.segFirst[0];
    end else begin : g_cn
      assign cin = strobe.segFirst[i] ? 1'b1 : segCarry[i-1];
    end

    assign segSum = {1'b0, opA[i*PIECE_W +: PIECE_W]}
                  + {1'b0, opB[i*PIECE_W +: PIECE_W]}
                  + {{PIECE_W{1'b0}}, cin};
    assign segCarry[i] = segSum[PIECE_W];
    assign sumVec[i*PIECE_W +: PIECE_W] = segSum[PIECE_W-1:0];
    assign aTop = opA[(i+1)*PIECE_W-1];
    assign bTop = opB[(i+1)*PIECE_W-1];
    // bit above the lane's top bit of the widened sum
    assign segExt[i] = strobe.signedLanes ? (aTop ^ bTop ^ segCarry[i]) : segCarry[i];

    assign halved[i*PIECE_W +: PIECE_W-1] = sumVec[i*PIECE_W+1 +: PIECE_W-1];
    if (i == PIECES-1) begin : g_tl
      assign halved[(i+1)*PIECE_W-1] = strobe.segLast[i] ? segExt[i] : 1'b0;
    end else begin : g_tn
      assign halved[(i+1)*PIECE_W-1] = strobe.segLast[i] ? segExt[i]
                                                         : sumVec[(i+1)*PIECE_W];
    end
  end

  always_comb begin
    if (strobe.illegal)      nextRes = '0;
    else if (strobe.upperOn) nextRes = halved;
    else                     nextRes = {{HALF_W{1'b0}}, halved[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst)              result <= '0;
    else if (strobe.load) result <= nextRes;
  end
endmodule

// File: rtl/simd_round_avg.sv
module simd_round_avg
  import ravg_pkg::*;
#(
  parameter int DATA_W  = VEC_W,
  parameter int PIECE_W = SEG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [1:0]        laneSize,
  input  logic              isUnsigned,
  input  logic              fullWidth,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              illegalOp
);
  dpCtrl_t strobe;

  ravg_ctrl #(.NUM_SEG(DATA_W / PIECE_W)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .laneSize(laneSize),
    .isUnsigned(isUnsigned), .fullWidth(fullWidth),
    .strobe(strobe), .outValid(outValid), .illegalOp(illegalOp)
  );

  ravg_dp #(.DATA_W(DATA_W), .PIECE_W(PIECE_W)) u_dp (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB),
    .strobe(strobe), .result(result)
  );
endmodule

// File: rtl/ravg_checker.sv
module ravg_checker #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [1:0]        laneSize,
  input logic              isUnsigned,
  input logic              fullWidth,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              illegalOp
);
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  p_valid_drops_r8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(inValid) |-> $stable(result));

  p_illegal_code_r7: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (illegalOp == ($past(laneSize) == 2'b11)));

  p_illegal_only_valid_r7: assert property (@(posedge clk) disable iff (rst)
    illegalOp |-> (outValid && result == '0));

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !$past(fullWidth)) |-> (result[DATA_W-1:DATA_W/2] == '0));

  // unsigned byte average stays between the two inputs
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(laneSize == 2'b00 && isUnsigned)) |->
      (((result[7:0] >= $past(opA[7:0])) || (result[7:0] >= $past(opB[7:0]))) &&
       ((result[7:0] <= $past(opA[7:0])) || (result[7:0] <= $past(opB[7:0])))));
endmodule

bind simd_round_avg ravg_checker #(.DATA_W(DATA_W)) u_ravg_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
  .laneSize(laneSize), .isUnsigned(isUnsigned), .fullWidth(fullWidth),
  .outValid(outValid), .result(result), .illegalOp(illegalOp)
);

// File: tb/test_simd_round_avg.sv
`timescale 1ns/1ps
module test_simd_round_avg;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [127:0] opA = '0;
  logic [127:0] opB = '0;
  logic [1:0]   laneSize = 2'b00;
  logic         isUnsigned = 1'b0;
  logic         fullWidth = 1'b1;
  logic         outValid;
  logic [127:0] result;
  logic         illegalOp;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic         expValid = 1'b0;
  logic         expIll = 1'b0;
  logic [127:0] expRes = '0;
  string        expTag = "R9";

  always #4 clk = ~clk;

  simd_round_avg i_simd_round_avg (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .laneSize(laneSize), .isUnsigned(isUnsigned), .fullWidth(fullWidth),
    .outValid(outValid), .result(result), .illegalOp(illegalOp)
  );

  function automatic logic [127:0] refAvg(input logic [127:0] a, input logic [127:0] b,
                                          input logic [1:0] sz, input logic uns,
                                          input logic full);
    logic [127:0] r = '0;
    int w;
    longint mask, x, y, s;
    if (sz == 2'b11) return '0;
    w = 8 << sz;
    mask = (longint'(1) << w) - 1;
    for (int l = 0; l < 128 / w; l++) begin
      if (!full && (l * w) >= 64) continue;
      x = longint'((a >> (l * w)) & 128'(mask));
      y = longint'((b >> (l * w)) & 128'(mask));
      if (!uns && x[w-1]) x = x - (longint'(1) << w);
      if (!uns && y[w-1]) y = y - (longint'(1) << w);
      s = (x + y + 1) >>> 1;
      r = r | (128'(s & mask) << (l * w));
    end
    return r;
  endfunction

  task automatic compareNow();
    checks++;
    if (outValid !== expValid || illegalOp !== expIll || result !== expRes) begin
      failures++;
      $display("FAIL %s: valid=%b ill=%b res=%h expected valid=%b ill=%b res=%h",
               expTag, outValid, illegalOp, result, expValid, expIll, expRes);
    end
  endtask

  // called on a falling edge: check last cycle, drive next
  task automatic step(input logic v, input logic [127:0] a, input logic [127:0] b,
                      input logic [1:0] sz, input logic uns, input logic full,
                      input string tag);
    compareNow();
    inValid = v; opA = a; opB = b; laneSize = sz; isUnsigned = uns; fullWidth = full;
    expTag = tag;
    if (v) begin
      expValid = 1'b1;
      expIll   = (sz == 2'b11);
      expRes   = refAvg(a, b, sz, uns, full);
    end else begin
      expValid = 1'b0;
      expIll   = 1'b0;
    end
    @(negedge clk);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] fillByte(input logic [7:0] v);
    return {16{v}};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: first comparison sees reset state
    // R1 unsigned byte extremes
    step(1, fillByte(8'hFF), fillByte(8'hFF), 2'b00, 1, 1, "R1");
    step(1, fillByte(8'hFF), fillByte(8'h00), 2'b00, 1, 1, "R1");
    step(1, fillByte(8'h01), fillByte(8'h02), 2'b00, 1, 1, "R1");
    // R2 signed byte extremes
    step(1, fillByte(8'h80), fillByte(8'h80), 2'b00, 0, 1, "R2");
    step(1, fillByte(8'h7F), fillByte(8'h7F), 2'b00, 0, 1, "R2");
    step(1, fillByte(8'hFF), fillByte(8'h00), 2'b00, 0, 1, "R2");
    step(1, fillByte(8'h80), fillByte(8'h7F), 2'b00, 0, 1, "R2");
    step(1, fillByte(8'hFD), fillByte(8'h00), 2'b00, 0, 1, "R2");
    // R3 wider lanes
    step(1, {8{16'hFFFF}}, {8{16'h0001}}, 2'b01, 1, 1, "R3");
    step(1, {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}}, 2'b10, 1, 1, "R3");
    step(1, {4{32'h8000_0000}}, {4{32'h7FFF_FFFF}}, 2'b10, 0, 1, "R3");
    step(1, {8{16'h8000}}, {8{16'h8000}}, 2'b01, 0, 1, "R3");
    // R4 same operands in both modes
    step(1, fillByte(8'hFF), fillByte(8'h01), 2'b00, 0, 1, "R4");
    step(1, fillByte(8'hFF), fillByte(8'h01), 2'b00, 1, 1, "R4");
    // R5 carry isolation at every width
    step(1, fillByte(8'hFF), fillByte(8'h01), 2'b00, 1, 1, "R5");
    step(1, {128{1'b1}}, {128{1'b1}}, 2'b01, 1, 1, "R5");
    step(1, {128{1'b1}}, {4{32'h0000_0001}}, 2'b10, 1, 1, "R5");
    step(1, {128{1'b1}}, {8{16'h0001}}, 2'b01, 0, 1, "R5");
    // R6 half width
    step(1, rnd128(), rnd128(), 2'b00, 0, 0, "R6");
    step(1, {128{1'b1}}, {128{1'b1}}, 2'b10, 1, 0, "R6");
    step(1, rnd128(), rnd128(), 2'b01, 1, 0, "R6");
    // R7 reserved size code
    step(1, rnd128(), rnd128(), 2'b11, 0, 1, "R7");
    step(1, rnd128(), rnd128(), 2'b11, 1, 0, "R7");
    // R8 idle cycles hold the result, then resume
    step(0, rnd128(), rnd128(), 2'b00, 1, 1, "R8");
    step(1, rnd128(), rnd128(), 2'b10, 0, 1, "R8");
    step(0, rnd128(), rnd128(), 2'b01, 1, 0, "R8");
    step(0, rnd128(), rnd128(), 2'b11, 1, 1, "R8");
    // random mix
    for (int k = 0; k < 300; k++) begin
      step(($urandom % 4) != 0, rnd128(), rnd128(), 2'($urandom % 4),
           1'($urandom), 1'($urandom), "R1");
    end
    step(0, '0, '0, 2'b00, 0, 1, "R8");
    compareNow();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R8: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule